// File: doc/BRIEF.md
# Lane-Split Integer Dot-Product Front End

This block is the first part of an integer dot-product engine. On each accepted transfer it receives two 128-bit words, one from each operand stream: for example a matrix row stream and a stored vector stream. It cuts both words into lanes of a width chosen at build time, which can be 8, 16, 32 or 64 bits. It multiplies matching lanes as signed two's-complement numbers. It then adds the products through a balanced binary tree, giving one exact partial sum per word pair. A later stage that accumulates across words uses these partial sums.

The two operand words share one valid/ready handshake. A flag that marks the final word of a vector enters with the operands and leaves with the matching partial sum, so the downstream stage knows where a dot product closes. The multiply stage and every tree level each end in a register. When the consumer holds back, the whole pipeline freezes in place.

Top module: `lanedot_top`

## Requirements
- R1: A word pair is taken in on a rising edge where `inValid` and `inReady` are both high. `inReady` is high whenever the output holds no result or `sumReady` is high. In particular, it is high just after reset.
- R2: During and just after reset, `sumValid` and `sumLast` are low.
- R3: With lane width s, lane i occupies bits [i*s +: s] of each word, so lane 0 is the least significant s bits. Each lane is a signed two's-complement value. `sumData` is the exact signed sum, over all 128/s lanes, of the products of matching lanes. It is 2s + log2(128/s) bits wide, so it never overflows.
- R4: With `sumReady` held high, a pair accepted on one edge gives its result on `sumData` with `sumValid` high after 1 + log2(128/s) rising edges.
- R5: `sumLast` is high with a result exactly when the matching input transfer had `inLast` high.
- R6: While `sumValid` is high and `sumReady` is low, the next cycle still shows `sumValid` high with `sumData` and `sumLast` unchanged.
- R7: Results leave in acceptance order. Each accepted pair yields exactly one result, with none lost and none repeated.
- R8: Lane widths of 8, 16, 32 and 64 bits all give correct results. The 64-bit build reduces its two products with a single adder.
- R9: With `sumReady` held high, `inReady` stays high, and a new pair can be accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| aWord | input | 128 | First operand word, packed lanes |
| bWord | input | 128 | Second operand word, packed lanes |
| inValid | input | 1 | Operand pair is offered |
| inLast | input | 1 | Offered pair is the final one of a vector |
| inReady | output | 1 | Block can take the offered pair |
| sumData | output | 2*LANE_W+log2(128/LANE_W) | Signed partial sum for one word pair |
| sumValid | output | 1 | `sumData` holds a result |
| sumLast | output | 1 | Result closes a vector |
| sumReady | input | 1 | Consumer takes the result |

## Verification
The output-side properties rely on the upstream side keeping an offered pair, together with its flag, steady until it is taken. They also rely on `sumReady` always being driven to a known level. The stimulus satisfies this by changing the operands only right after a cycle in which the pair was accepted. It toggles `sumReady` at random, so stalls of varied length reach every pipeline depth. Operand words mix random values with directed lane patterns: most negative, most positive, all minus one, and a value in lane 0 only. This exercises sign extension and the widening of the tree at each of the four lane widths.

// File: rtl/lanedot_pkg.sv
package lanedot_pkg;
  localparam int WORD_W = 128;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;   // every stage register moves one step
    logic mulLoad;   // product stage captures a new pair
  } stb_t;
endpackage

// File: rtl/lanedot_ctrl.sv
module lanedot_ctrl
  import lanedot_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic inLast,
  output logic inReady,
  input  logic sumReady,
  output logic sumValid,
  output logic sumLast,
  output stb_t stb
);
  logic [STAGES-1:0] vldPipe;
  logic [STAGES-1:0] lastPipe;
  logic advance;

  // whole pipe moves unless the output holds a result nobody takes
  assign advance = sumReady || !vldPipe[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vldPipe  <= '0;
      lastPipe <= '0;
    end else if (advance) begin
      vldPipe  <= {vldPipe[STAGES-2:0], inValid};
      lastPipe <= {lastPipe[STAGES-2:0], inValid & inLast};
    end
  end

  always_comb begin
    stb.advance = advance;
    stb.mulLoad = advance & inValid;
  end

  assign inReady  = advance;
  assign sumValid = vldPipe[STAGES-1];
  assign sumLast  = lastPipe[STAGES-1];
endmodule

// File: rtl/lanedot_dp.sv
module lanedot_dp
  import lanedot_pkg::*;
#(
  parameter  int LANE_W = 16,
  localparam int LANES  = WORD_W / LANE_W,
  localparam int DEPTH  = $clog2(LANES),
  localparam int SUM_W  = 2 * LANE_W + DEPTH
) (
  input  logic              clk,
  input  stb_t              stb,
  input  logic [WORD_W-1:0] aWord,
  input  logic [WORD_W-1:0] bWord,
  output logic [SUM_W-1:0]  sumWord
);
  // level 0 holds products, level l holds LANES>>l sums one bit wider each step
  for (genvar l = 0; l <= DEPTH; l++) begin : lv
    localparam int CNT = LANES >> l;
    localparam int W   = 2 * LANE_W + l;
    logic signed [W-1:0] node [CNT];

    if (l == 0) begin : mulStage
      for (genvar i = 0; i < CNT; i++) begin : lane
        always_ff @(posedge clk) begin
          if (stb.mulLoad)
            node[i] <= W'($signed(aWord[i*LANE_W +: LANE_W]))
                     * W'($signed(bWord[i*LANE_W +: LANE_W]));
        end
      end
    end else begin : addStage
      for (genvar j = 0; j < CNT; j++) begin : pair
        always_ff @(posedge clk) begin
          if (stb.advance)
            node[j] <= W'(lv[l-1].node[2*j]) + W'(lv[l-1].node[2*j+1]);
        end
      end
    end
  end

  assign sumWord = lv[DEPTH].node[0];
endmodule

// File: rtl/lanedot_top.sv
module lanedot_top
  import lanedot_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic [WORD_W-1:0]                      aWord,
  input  logic [WORD_W-1:0]                      bWord,
  input  logic                                   inValid,
  input  logic                                   inLast,
  output logic                                   inReady,
  output logic [2*LANE_W+$clog2(WORD_W/LANE_W)-1:0] sumData,
  output logic                                   sumValid,
  output logic                                   sumLast,
  input  logic                                   sumReady
);
  localparam int LANES  = WORD_W / LANE_W;
  localparam int DEPTH  = $clog2(LANES);
  localparam int SUM_W  = 2 * LANE_W + DEPTH;
  localparam int STAGES = DEPTH + 1;

  stb_t stb;

  lanedot_ctrl #(.STAGES(STAGES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inLast   (inLast),
    .inReady  (inReady),
    .sumReady (sumReady),
    .sumValid (sumValid),
    .sumLast  (sumLast),
    .stb      (stb)
  );

  lanedot_dp #(.LANE_W(LANE_W)) uDp (
    .clk     (clk),
    .stb     (stb),
    .aWord   (aWord),
    .bWord   (bWord),
    .sumWord (sumData)
  );
endmodule

// File: rtl/lanedot_chk.sv
module lanedot_chk #(
  parameter int SUM_W = 35
) (
  input logic             clk,
  input logic             rstN,
  input logic             inReady,
  input logic             sumValid,
  input logic             sumLast,
  input logic             sumReady,
  input logic [SUM_W-1:0] sumData
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    sumValid && !sumReady |=> sumValid && $stable(sumData) && $stable(sumLast)); // R6

  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rstN)
    !sumValid |-> inReady); // R1

  AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rstN)
    sumReady |-> inReady); // R9

  AST_LAST_QUAL: assert property (@(posedge clk) disable iff (!rstN)
    sumLast |-> sumValid); // R5
endmodule

bind lanedot_top lanedot_chk #(.SUM_W(SUM_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .inReady  (inReady),
  .sumValid (sumValid),
  .sumLast  (sumLast),
  .sumReady (sumReady),
  .sumData  (sumData)
);

// File: tb/tb_lanedot_top.sv
module lanedot_harness #(
  parameter int LANE_W = 16
) (
  input  logic clk,
  input  logic rstN,
  output int   nChk,
  output int   nErr,
  output logic done
);
  localparam int LANES = 128 / LANE_W;
  localparam int DEPTH = $clog2(LANES);
  localparam int SUM_W = 2 * LANE_W + DEPTH;
  localparam int LAT   = DEPTH + 1;

  typedef struct {
    logic signed [139:0] val;
    logic                last;
  } exp_t;

  logic [127:0]     inA, inB;
  logic             inValid, inLast, inReady;
  logic [SUM_W-1:0] sumData;
  logic             sumValid, sumLast, sumReady;

  exp_t             expQ[$];
  int               pushes, pops;
  bit               stallPrev;
  logic [SUM_W-1:0] holdData;
  logic             holdLast;

  lanedot_top #(.LANE_W(LANE_W)) dut (
    .clk(clk), .rstN(rstN), .aWord(inA), .bWord(inB),
    .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .sumData(sumData), .sumValid(sumValid), .sumLast(sumLast),
    .sumReady(sumReady)
  );

  function automatic logic signed [139:0] refDot(input logic [127:0] a, input logic [127:0] b);
    logic signed [139:0] acc = 0;
    for (int i = 0; i < LANES; i++) begin
      logic signed [139:0] x, y;
      x = 140'((a >> (i * LANE_W)) & ((128'd1 << LANE_W) - 1));
      y = 140'((b >> (i * LANE_W)) & ((128'd1 << LANE_W) - 1));
      if (x[LANE_W-1]) x = x - (140'sd1 <<< LANE_W);
      if (y[LANE_W-1]) y = y - (140'sd1 <<< LANE_W);
      acc = acc + x * y;
    end
    return acc;
  endfunction

  // 0: most negative lanes, 1: most positive, 2: all -1, 3: lane 0 = 5 only
  function automatic logic [127:0] pattern(input int kind);
    logic [127:0] w = '0;
    for (int k = 0; k < 128; k++) begin
      int p = k % LANE_W;
      case (kind)
        0:       w[k] = (p == LANE_W - 1);
        1:       w[k] = (p != LANE_W - 1);
        2:       w[k] = 1'b1;
        default: w[k] = (k < LANE_W) && (((5 >> k) & 1) == 1);
      endcase
    end
    return w;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(input bit ok, input string tag, input logic signed [139:0] act,
                       input logic signed [139:0] exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s lane=%0d: actual %0d expected %0d", tag, LANE_W, act, exp);
    end
  endtask

  // one cycle: drive after the falling edge, sample shortly after
  task automatic tick(input bit v, input logic [127:0] a, input logic [127:0] b,
                      input bit l, input bit rdy, output bit acc);
    @(negedge clk);
    inValid = v; inA = a; inB = b; inLast = l; sumReady = rdy;
    #1;
    if (stallPrev) begin
      check(sumValid === 1'b1, "R6 valid held in stall", 140'(sumValid), 1);
      check(sumData === holdData, "R6 data held in stall",
            $signed(sumData), $signed(holdData));
      check(sumLast === holdLast, "R6 last held in stall", 140'(sumLast), 140'(holdLast));
    end
    if (sumValid && sumReady) begin
      if (expQ.size() == 0) begin
        check(0, "R7 unexpected result", 1, 0);
      end else begin
        exp_t e = expQ.pop_front();
        check($signed(sumData) == e.val, "R3 dot value", $signed(sumData), e.val);
        check(sumLast === e.last, "R5 last flag", 140'(sumLast), 140'(e.last));
      end
      pops++;
    end
    stallPrev = sumValid && !sumReady;
    holdData  = sumData;
    holdLast  = sumLast;
    acc = inValid && inReady;
    if (acc) begin
      exp_t n;
      n.val = refDot(inA, inB);
      n.last = inLast;
      expQ.push_back(n);
      pushes++;
    end
  endtask

  task automatic pushWord(input logic [127:0] a, input logic [127:0] b, input bit l,
                          input bit rdyRand, output int ticks);
    bit acc;
    ticks = 0;
    do begin
      bit rdy = rdyRand ? (($urandom % 100) < 65) : 1'b1;
      tick(1'b1, a, b, l, rdy, acc);
      ticks++;
    end while (!acc);
  endtask

  task automatic idle(input bit rdy);
    bit acc;
    tick(1'b0, '0, '0, 1'b0, rdy, acc);
  endtask

  initial begin
    int ticks;
    int startPops;
    int n;
    logic [127:0] da[6];
    logic [127:0] db[6];
    nChk = 0; nErr = 0; done = 0;
    pushes = 0; pops = 0; stallPrev = 0;
    inValid = 0; inLast = 0; inA = '0; inB = '0; sumReady = 0;
    void'($urandom(1000 + LANE_W));

    wait (rstN === 1'b1);
    @(negedge clk);
    #1;
    check(sumValid === 1'b0, "R2 valid low after reset", 140'(sumValid), 0);
    check(sumLast === 1'b0, "R2 last low after reset", 140'(sumLast), 0);
    check(inReady === 1'b1, "R1 ready when empty", 140'(inReady), 1);

    // R4: latency of a lone word with the consumer always ready
    repeat (3) idle(1'b1);
    pushWord(rnd128(), rnd128(), 1'b1, 1'b0, ticks);
    startPops = pops;
    n = 0;
    for (int k = 1; k <= 20; k++) begin
      idle(1'b1);
      if (pops != startPops) begin n = k; break; end
    end
    check(n == LAT, "R4 latency", n, LAT);

    // directed corners back to back; R9 wants one tick per word
    da[0] = pattern(0); db[0] = pattern(0);
    da[1] = pattern(1); db[1] = pattern(0);
    da[2] = pattern(1); db[2] = pattern(1);
    da[3] = pattern(2); db[3] = pattern(2);
    da[4] = pattern(3); db[4] = pattern(2);
    da[5] = '0;         db[5] = rnd128();
    for (int k = 0; k < 6; k++) begin
      pushWord(da[k], db[k], (k % 2) == 1, 1'b0, ticks);
      check(ticks == 1, "R9 full rate accept", ticks, 1);
    end
    repeat (LAT + 2) idle(1'b1);

    // random phase with stalls, gaps and extreme lanes mixed in
    for (int k = 0; k < 250; k++) begin
      logic [127:0] a = rnd128();
      logic [127:0] b = rnd128();
      if (($urandom % 8) == 0) a = pattern($urandom % 4);
      if (($urandom % 8) == 0) b = pattern($urandom % 4);
      pushWord(a, b, ($urandom % 4) == 0, 1'b1, ticks);
      if (($urandom % 3) == 0) idle(($urandom % 2) == 0);
    end

    repeat (LAT + 10) idle(1'b1);
    check(expQ.size() == 0, "R7 nothing left unreturned", expQ.size(), 0);
    check(pops == pushes, "R8 result count for this lane width", pops, pushes);
    done = 1;
  end
endmodule

module tb_lanedot_top;
  logic clk = 0;
  logic rstN = 0;
  always #10 clk = ~clk;   // 50 MHz

  int   c8, e8, c16, e16, c32, e32, c64, e64;
  logic d8, d16, d32, d64;
  bit   timedOut = 0;

  lanedot_harness #(.LANE_W(8))  u8  (.clk(clk), .rstN(rstN), .nChk(c8),  .nErr(e8),  .done(d8));
  lanedot_harness #(.LANE_W(16)) u16 (.clk(clk), .rstN(rstN), .nChk(c16), .nErr(e16), .done(d16));
  lanedot_harness #(.LANE_W(32)) u32 (.clk(clk), .rstN(rstN), .nChk(c32), .nErr(e32), .done(d32));
  lanedot_harness #(.LANE_W(64)) u64 (.clk(clk), .rstN(rstN), .nChk(c64), .nErr(e64), .done(d64));

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
  end

  initial begin
    int errs;
    int total;
    fork
      begin
        wait (d8 === 1'b1 && d16 === 1'b1 && d32 === 1'b1 && d64 === 1'b1);
      end
      begin
        repeat (100000) @(posedge clk);
        timedOut = 1;
      end
    join_any
    disable fork;
    errs  = e8 + e16 + e32 + e64;
    total = c8 + c16 + c32 + c64;
    if (timedOut) begin
      errs++;
      total++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule